// File: doc/BRIEF.md
# Serial Converter Read-Out Framer with Power Modes

This block is the digital control side of a sampling converter that is read over a three-wire serial link. It watches an active-low chip select and an external serial clock, both already synchronous to the block clock and sampled on every rising edge of it. A falling chip select starts a frame. The block then takes a parallel result from a stand-in successive-approximation core and sends it out as a 16-bit word. The word begins with four zeros, then the result most significant bit first, then zero padding. The result width is a parameter: 12, 10 or 8 bits.

The block also drives the track/hold status and a two-state power mode, normal or shutdown. The mode changes according to where chip select rises within a frame, counted in falling edges of the serial clock. A frame started from shutdown powers the converter up, so its result is a dummy. A result-valid flag, updated whenever a word completes, tells real results apart from dummy ones. The serial data pin is modelled as a data bit plus an output enable. The enclosing pad ring builds the tri-state driver from the two.

Top module: `adc_serial_framer`

## Requirements
- R1: On the clock after chip select is first seen low following a high, the output enable and the hold status both go to 1, and the data bit shows the first leading zero. The serial clock may idle high or low before the frame.
- R2: After the k-th counted falling serial clock edge of a frame (k = 0..15), the data bit shows bit k of a 16-bit word. Word bits 0 to 3 are 0. Word bits 4 to 3+RES_BITS carry the result, most significant bit first. The remaining 12-RES_BITS bits are 0, which gives 0, 2 or 4 trailing zeros. The code is plain unsigned binary, captured when chip select falls.
- R3: The hold status returns to 0 on the 13th rising serial clock edge of a frame, or earlier if chip select rises.
- R4: The output enable returns to 0 on the 16th falling edge or on a chip select rise, whichever comes first. The 16th falling edge also gives a one-cycle word-done pulse. While the output enable is 0, the data bit is 0.
- R5: In normal mode, if chip select rises after 2 to 9 counted falling edges, the word is dropped and the mode becomes shutdown.
- R6: In normal mode, if chip select rises after 0 or 1 falling edges, the mode stays normal.
- R7: If chip select rises after 10 to 15 falling edges, the word is cut short and the mode is normal.
- R8: A frame started in shutdown switches the mode to normal on its 10th falling edge. If chip select rises before that edge, the mode stays shutdown.
- R9: At each word-done pulse the result-valid flag is updated. It becomes 0 if this is the first completed word since reset or since the last entry into shutdown, and 1 otherwise. It keeps its value between pulses.
- R10: After reset the mode is shutdown, and the output enable, hold status, data bit, result-valid flag and word-done pulse are all 0.
- R11: Falling edges after the 16th in a frame shift nothing, re-enable nothing and give no second word-done pulse. A new frame needs chip select to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; chip select and serial clock are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock level |
| code_i | input | RES_BITS | Parallel result from the stand-in converter core |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| hold_o | output | 1 | 1 while the sample is held, 0 while tracking |
| shutdown_o | output | 1 | 1 in shutdown mode, 0 in normal mode |
| result_valid_o | output | 1 | 0 when the last completed word was a dummy conversion |
| word_done_o | output | 1 | One-cycle pulse on the 16th falling edge of a frame |

## Verification
A wrong falling-edge count shows up on the data bit within one serial clock period, because the word bits move by one position. The same wrong count also moves the mode decision at a chip select rise: the block enters or skips shutdown at the wrong place, and `shutdown_o` shows the difference on the next clock. A lost power-up state does not show until the next completed word, where `result_valid_o` takes the wrong value at the word-done pulse. The bench therefore runs aborts at every boundary (0, 1, 2..9 and 10..15 edges), from both modes, and follows each abort with full frames.

// File: rtl/adc_framer_pkg.sv
// Package: constants and types shared by the serial read-out framer.
// Assumes a fixed 16-bit word with four leading zeros.
package adc_framer_pkg;
    localparam int WORD_BITS      = 16;
    localparam int LEAD_BITS      = 4;
    localparam int SLEEP_MIN_EDGE = 2;   // first falling edge count at which a rise powers down
    localparam int WAKE_EDGE      = 10;  // falling edge that commits normal mode
    localparam int TRACK_EDGE     = 13;  // rising edge that releases the hold
    localparam int CNT_W          = $clog2(WORD_BITS + 1);

    typedef enum logic {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_mode_e;
endpackage

// File: rtl/afe_edge_sense.sv
// Module: afe_edge_sense
// Finds edges of chip select and the serial clock by comparing each sampled
// level with the level from the previous block clock.
// Assumes both inputs are already synchronous to clk.
// Chip select is taken as high during reset, so a low level at release counts as a fall.
module afe_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic sck_fall_o,
    output logic sck_rise_o
);
    logic cs_q;
    logic sck_q;

    // Keep last sampled levels of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n_i;
            sck_q <= sclk_i;
        end
    end

    assign cs_fall_o  = cs_q & ~cs_n_i;
    assign cs_rise_o  = ~cs_q & cs_n_i;
    assign sck_fall_o = sck_q & ~sclk_i;
    assign sck_rise_o = ~sck_q & sclk_i;
endmodule

// File: rtl/afe_frame_seq.sv
// Module: afe_frame_seq
// Counts serial clock falling and rising edges inside a chip select frame.
// Both counters saturate at the word length. The module drives the hold status.
// Assumes that a chip select event and a serial clock edge never land in the
// same block clock; if they do, the chip select event wins.
module afe_frame_seq
    import adc_framer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall_i,
    input  logic             cs_rise_i,
    input  logic             sck_fall_i,
    input  logic             sck_rise_i,
    output logic             in_frame_o,
    output logic [CNT_W-1:0] fall_cnt_o,
    output logic             tick_fall_o,
    output logic             word_end_o,
    output logic             wake_edge_o,
    output logic             hold_o
);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] WAKE_CNT  = CNT_W'(WAKE_EDGE - 1);
    localparam logic [CNT_W-1:0] TRACK_CNT = CNT_W'(TRACK_EDGE - 1);

    logic             in_frame_q;
    logic             hold_q;
    logic [CNT_W-1:0] fcnt_q;
    logic [CNT_W-1:0] rcnt_q;
    logic             quiet_cs;
    logic             rise_ok;

    assign quiet_cs    = ~cs_fall_i & ~cs_rise_i;
    assign tick_fall_o = in_frame_q & quiet_cs & sck_fall_i & (fcnt_q != FULL_CNT);
    assign rise_ok     = in_frame_q & quiet_cs & sck_rise_i & (rcnt_q != FULL_CNT);
    assign word_end_o  = tick_fall_o & (fcnt_q == LAST_CNT);
    assign wake_edge_o = tick_fall_o & (fcnt_q == WAKE_CNT);

    // Frame flag, edge counters and hold status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            hold_q     <= 1'b0;
            fcnt_q     <= '0;
            rcnt_q     <= '0;
        end else if (cs_fall_i) begin
            in_frame_q <= 1'b1;
            hold_q     <= 1'b1;
            fcnt_q     <= '0;
            rcnt_q     <= '0;
        end else if (cs_rise_i) begin
            in_frame_q <= 1'b0;
            hold_q     <= 1'b0;
        end else begin
            if (tick_fall_o) fcnt_q <= fcnt_q + 1'b1;
            if (rise_ok) begin
                rcnt_q <= rcnt_q + 1'b1;
                if (rcnt_q == TRACK_CNT) hold_q <= 1'b0;
            end
        end
    end

    assign in_frame_o = in_frame_q;
    assign fall_cnt_o = fcnt_q;
    assign hold_o     = hold_q;
endmodule

// File: rtl/afe_mode_ctrl.sv
// Module: afe_mode_ctrl
// Power mode state and the dummy-conversion tracking.
// The mode goes to shutdown when a normal-mode frame is dropped between the
// 2nd and 10th falling edges. It goes to normal on the 10th falling edge of any frame.
// Assumes fall_cnt_i is the count before the current clock's update.
module afe_mode_ctrl
    import adc_framer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise_i,
    input  logic             in_frame_i,
    input  logic [CNT_W-1:0] fall_cnt_i,
    input  logic             wake_edge_i,
    input  logic             word_end_i,
    output logic             shutdown_o,
    output logic             result_valid_o,
    output logic             word_done_o
);
    pwr_mode_e mode_q;
    logic      warm_q;
    logic      valid_q;
    logic      done_q;
    logic      sleep_req;

    assign sleep_req = cs_rise_i & in_frame_i & (mode_q == PWR_ON)
                     & (fall_cnt_i >= CNT_W'(SLEEP_MIN_EDGE))
                     & (fall_cnt_i <  CNT_W'(WAKE_EDGE));

    // Power mode register; reset lands in shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= PWR_OFF;
        else if (sleep_req)   mode_q <= PWR_OFF;
        else if (wake_edge_i) mode_q <= PWR_ON;
    end

    // Warm-up flag, result-valid flag and word-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q  <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= word_end_i;
            if (sleep_req) begin
                warm_q <= 1'b0;
            end else if (word_end_i) begin
                valid_q <= warm_q;
                warm_q  <= 1'b1;
            end
        end
    end

    assign shutdown_o     = (mode_q == PWR_OFF);
    assign result_valid_o = valid_q;
    assign word_done_o    = done_q;
endmodule

// File: rtl/afe_word_shifter.sv
// Module: afe_word_shifter
// Builds the 16-bit word from the result when chip select falls and shifts it
// out MSB first, one bit per counted falling edge. The module also owns the output enable.
// Assumes 4 + RES_BITS <= 16.
module afe_word_shifter
    import adc_framer_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_fall_i,
    input  logic                cs_rise_i,
    input  logic                tick_fall_i,
    input  logic                word_end_i,
    input  logic [RES_BITS-1:0] code_i,
    output logic                sdo_o,
    output logic                sdo_oe_o
);
    localparam int PAD_BITS = WORD_BITS - LEAD_BITS - RES_BITS;

    logic [WORD_BITS-1:0] sh_q;
    logic [WORD_BITS-1:0] word_in;
    logic                 oe_q;

    assign word_in = WORD_BITS'(code_i) << PAD_BITS;

    // Load, shift and enable control for the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (cs_fall_i) begin
            sh_q <= word_in;
            oe_q <= 1'b1;
        end else if (cs_rise_i) begin
            oe_q <= 1'b0;
        end else if (tick_fall_i) begin
            sh_q <= sh_q << 1;
            if (word_end_i) oe_q <= 1'b0;
        end
    end

    assign sdo_o    = oe_q & sh_q[WORD_BITS-1];
    assign sdo_oe_o = oe_q;
endmodule

// File: rtl/adc_serial_framer.sv
// Module: adc_serial_framer (top)
// Digital control for a serially read sampling converter: edge sensing,
// frame sequencing, power mode and output word framing.
// Assumes cs_n_i and sclk_i are synchronous to clk. Each serial clock level
// must last at least one block clock.
module adc_serial_framer
    import adc_framer_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_i,
    input  logic                sclk_i,
    input  logic [RES_BITS-1:0] code_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic                hold_o,
    output logic                shutdown_o,
    output logic                result_valid_o,
    output logic                word_done_o
);
    logic             cs_fall, cs_rise, sck_fall, sck_rise;
    logic             in_frame, tick_fall, word_end, wake_edge;
    logic [CNT_W-1:0] fall_cnt;

    afe_edge_sense u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .sclk_i     (sclk_i),
        .cs_fall_o  (cs_fall),
        .cs_rise_o  (cs_rise),
        .sck_fall_o (sck_fall),
        .sck_rise_o (sck_rise)
    );

    afe_frame_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sck_fall_i  (sck_fall),
        .sck_rise_i  (sck_rise),
        .in_frame_o  (in_frame),
        .fall_cnt_o  (fall_cnt),
        .tick_fall_o (tick_fall),
        .word_end_o  (word_end),
        .wake_edge_o (wake_edge),
        .hold_o      (hold_o)
    );

    afe_mode_ctrl u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_rise_i      (cs_rise),
        .in_frame_i     (in_frame),
        .fall_cnt_i     (fall_cnt),
        .wake_edge_i    (wake_edge),
        .word_end_i     (word_end),
        .shutdown_o     (shutdown_o),
        .result_valid_o (result_valid_o),
        .word_done_o    (word_done_o)
    );

    afe_word_shifter #(.RES_BITS(RES_BITS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .tick_fall_i (tick_fall),
        .word_end_i  (word_end),
        .code_i      (code_i),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o)
    );
endmodule

// File: rtl/adc_serial_framer_chk.sv
// Module: adc_serial_framer_chk
// Port-level temporal checks for the framer, bound into every instance of it.
module adc_serial_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic sclk_i,
    input logic sdo_oe_o,
    input logic hold_o,
    input logic shutdown_o,
    input logic word_done_o
);
    // R1
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_i) |=> (sdo_oe_o && hold_o));

    // R4
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_i) |=> !sdo_oe_o);

    // R4
    word_done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |-> !sdo_oe_o);

    // R3
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> (($past(sclk_i) && !$past(sclk_i, 2)) ||
                           ($past(cs_n_i) && !$past(cs_n_i, 2))));

    // R5
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

    // R8
    wake_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_o) |-> (!$past(sclk_i) && $past(sclk_i, 2)));

    // R9
    done_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |-> !shutdown_o);
endmodule

bind adc_serial_framer adc_serial_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .sclk_i      (sclk_i),
    .sdo_oe_o    (sdo_oe_o),
    .hold_o      (hold_o),
    .shutdown_o  (shutdown_o),
    .word_done_o (word_done_o)
);

// File: tb/adc_serial_framer_tb_top.sv
`timescale 1ns/1ps
module adc_serial_framer_tb_top;
    localparam int RES  = 12;
    localparam int HALF = 2;   // serial clock half period in block clocks

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b0;
    logic [RES-1:0] code = '0;
    logic           sdo, sdo_oe, hold, shut, rvalid, wdone;

    int n_chk  = 0;
    int n_fail = 0;
    int done_seen = 0;
    bit compare_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    bit  m_cs = 1, m_sck = 0, m_in = 0, m_hold = 0, m_oe = 0, m_shut = 1;
    bit  m_warm = 0, m_valid = 0, m_done = 0;
    int  m_nf = 0, m_nr = 0;
    logic [15:0] m_word = '0;

    always #2 clk = ~clk;  // 250 MHz

    adc_serial_framer #(.RES_BITS(RES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .code_i(code),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold), .shutdown_o(shut),
        .result_valid_o(rvalid), .word_done_o(wdone)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model, then comparison just after every clock
    always @(posedge clk) begin
        bit csf, csr, scf, scr;
        if (!rst_n) begin
            m_cs = 1; m_sck = 0; m_in = 0; m_hold = 0; m_oe = 0; m_shut = 1;
            m_warm = 0; m_valid = 0; m_done = 0; m_nf = 0; m_nr = 0;
        end else begin
            csf = m_cs && !cs_n;  csr = !m_cs && cs_n;
            scf = m_sck && !sclk; scr = !m_sck && sclk;
            m_cs = cs_n; m_sck = sclk;
            m_done = 0;
            if (csf) begin
                m_in = 1; m_nf = 0; m_nr = 0; m_hold = 1; m_oe = 1;
                m_word = 16'(code) << (12 - RES);
            end else if (csr) begin
                if (m_in && !m_shut && m_nf >= 2 && m_nf <= 9) begin
                    m_shut = 1; m_warm = 0;
                end
                m_in = 0; m_hold = 0; m_oe = 0;
            end else if (m_in) begin
                if (scf && m_nf < 16) begin
                    m_nf++;
                    if (m_nf == 10) m_shut = 0;
                    if (m_nf == 16) begin
                        m_oe = 0; m_done = 1; m_valid = m_warm; m_warm = 1;
                    end
                end
                if (scr && m_nr < 16) begin
                    m_nr++;
                    if (m_nr == 13) m_hold = 0;
                end
            end
        end
        #1;
        if (compare_on) begin
            check(sdo, (m_oe && m_nf < 16) ? m_word[15 - m_nf] : 1'b0, "R2", "data bit");
            check(sdo_oe, m_oe, "R4", "output enable");
            check(hold, m_hold, "R3", "hold status");
            check(shut, m_shut, "R5", "shutdown mode");
            check(rvalid, m_valid, "R9", "result valid");
            check(wdone, m_done, "R4", "word done");
            if (wdone) done_seen++;
        end
    end

    // One frame: nfall serial clock periods, then chip select released.
    task automatic frame(input logic [RES-1:0] c, input int nfall, input bit idle_hi);
        @(negedge clk);
        code = c; sclk = idle_hi;
        done_seen = 0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: enable and hold up, leading zero on the pin
        check(sdo_oe, 1'b1, "R1", "enable after select");
        check(hold, 1'b1, "R1", "hold after select");
        check(sdo, 1'b0, "R1", "first leading zero");
        for (int k = 0; k < nfall; k++) begin
            sclk = ~idle_hi;
            repeat (HALF) @(negedge clk);
            sclk = idle_hi;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(shut, 1'b1, "R10", "shutdown after reset");
        check(sdo_oe, 1'b0, "R10", "enable after reset");
        check(hold, 1'b0, "R10", "hold after reset");
        check(rvalid, 1'b0, "R10", "valid after reset");

        frame(12'hABC, 16, 1'b0);
        check(shut, 1'b0, "R8", "wake frame commits normal");
        check(rvalid, 1'b0, "R9", "first word is dummy");
        frame(12'hFFF, 16, 1'b0);
        check(rvalid, 1'b1, "R9", "second word valid");
        frame(12'h800, 5, 1'b0);
        check(shut, 1'b1, "R5", "drop at 5 enters shutdown");
        frame(12'h001, 7, 1'b0);
        check(shut, 1'b1, "R8", "wake dropped at 7 stays off");
        frame(12'h5A5, 12, 1'b0);
        check(shut, 1'b0, "R7", "wake dropped at 12 is normal");
        check(done_seen == 0, 1'b1, "R7", "cut word gives no done");
        frame(12'h000, 16, 1'b0);
        check(rvalid, 1'b0, "R9", "dummy after shutdown");
        frame(12'h3C7, 16, 1'b0);
        check(rvalid, 1'b1, "R9", "valid after dummy");
        frame(12'hA5A, 1, 1'b0);
        check(shut, 1'b0, "R6", "drop at 1 keeps normal");
        frame(12'h111, 0, 1'b0);
        check(shut, 1'b0, "R6", "drop at 0 keeps normal");
        frame(12'h7E1, 2, 1'b0);
        check(shut, 1'b1, "R5", "drop at 2 enters shutdown");
        frame(12'h0F0, 10, 1'b0);
        check(shut, 1'b0, "R8", "wake reaches 10th edge");
        frame(12'h9D3, 9, 1'b0);
        check(shut, 1'b1, "R5", "drop at 9 enters shutdown");
        frame(12'h246, 16, 1'b1);
        check(shut, 1'b0, "R8", "wake with high idle clock");
        frame(12'hC33, 20, 1'b0);
        check(done_seen == 1, 1'b1, "R11", "one done pulse in long frame");
        check(rvalid, 1'b1, "R11", "long frame result valid");
        frame(12'h6B9, 15, 1'b1);
        check(shut, 1'b0, "R7", "drop at 15 keeps normal");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule